// File: doc/BRIEF.md
# DAC Bank Register Initialization Sequencer

This block brings a bank of SPI-attached DAC chips from power-on to a configured, two-lane-ready state without software involvement. On a start request it holds the shared active-low DAC reset line low for a fixed number of cycles and releases it. It then waits a settling time derived from the clock frequency and walks a fixed, computed list of single-byte register writes.

Each write is handed to a downstream single-lane SPI write engine as an address, a data byte and a chip-select mask. The sequencer holds the request until the engine answers with a one-cycle done pulse. The list enables the alert pull-ups and clears both status registers. It then configures every chip in ascending chip order with hardware load disabled, a 0 to 5 V range and an external reference. Next it clears both status registers again, and last it switches every chip's interface to two-lane mode. Writes that are not per-chip go to all chips at once. The level of the shared alert pin is brought out through a two-flop synchronizer.

Top module: `dac_init_seq`

## Requirements
- R1: `dac_rst_no` is low while idle after `rst_ni`. After a `start_i` pulse it is low for exactly `HOLD_CYCLES` cycles and then high for the rest of the run.
- R2: After the reset line is released, `wr_req_o` stays low for exactly SETTLE = `CLK_HZ`*`SETTLE_MS`/1000 cycles. The first request appears in the following cycle.
- R3: The first write is address 0x14 with data 0x44, and `wr_cs_o` is all ones.
- R4: A status clear is two writes with all chip selects set: address 0x11 with data 0x01, then address 0x17 with data 0x01. One clear directly follows R3, and a second one directly follows the last per-chip write.
- R5: For chip c = 0 up to `NUM_CHIPS`-1, in that order, four writes are made with only `wr_cs_o[c]` set. They are, in order: 0x1C with 0x00 (16-bit hardware load off), 0x1D with 0x00 (24-bit hardware load off), 0x1A with 0x11 (range 0 to 5 V on channels 0 and 1), and 0x15 with 0x02 (external reference).
- R6: The last write is address 0x0F with data 0x40 to all chips, which sets the two-bit I/O mode field in bits 7:6 to 0b01.
- R7: While `wr_req_o` is high and `wr_done_i` is low, the request and its address, data and selects stay unchanged. In the cycle after the done pulse, `wr_req_o` is low for exactly one cycle, and then the next write is presented.
- R8: `wr_done_i` has no effect while `wr_req_o` is low, that is during hold, settle, gap, idle or done.
- R9: `done_o` rises in the cycle after the done pulse of the final write and stays high until `start_i`. `busy_o` is high from the cycle after `start_i` until then, and low otherwise.
- R10: `start_i` in any state, including during the write list, restarts the whole run from the R1 reset hold.
- R11: `alert_o` equals the inverse of `alert_ni` delayed by two clock cycles, and is low during `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart the sequence |
| alert_ni | input | 1 | Shared active-low DAC alert pin |
| wr_done_i | input | 1 | Write engine done pulse |
| dac_rst_no | output | 1 | Active-low reset to all DAC chips |
| wr_req_o | output | 1 | Write request to the SPI engine |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 8 | Data byte of the current write |
| wr_cs_o | output | NUM_CHIPS | Chip-select mask, one bit per chip |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All writes complete |
| alert_o | output | 1 | Synchronized alert, high when asserted |

## Verification
The bench varies the engine latency from zero to three cycles, so a done pulse can land in the first cycle of a request. A design that advanced without waiting, or that skipped the one-cycle gap, would misorder or repeat writes. Done pulses are injected during settling and after completion, where a design that listens outside a request would start early or drop `done_o`. A restart in the middle of the per-chip writes catches a step index that is not cleared. Boundary counts on the hold and settle windows expose off-by-one timers, and the chip-select mask is compared on every write to catch a wrong chip ordering.

// File: rtl/dac_init_pkg.sv
package dac_init_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_SETTLE, ST_ISSUE, ST_GAP, ST_DONE
  } seq_state_e;

  localparam logic [7:0] A_IFCFG   = 8'h14;
  localparam logic [7:0] A_IFSTAT  = 8'h11;
  localparam logic [7:0] A_ERRSTAT = 8'h17;
  localparam logic [7:0] A_XFER    = 8'h0F;
  localparam logic [7:0] A_LOAD16  = 8'h1C;
  localparam logic [7:0] A_LOAD24  = 8'h1D;
  localparam logic [7:0] A_RANGE   = 8'h1A;
  localparam logic [7:0] A_VREF    = 8'h15;

  localparam logic [7:0] D_PULLUP  = 8'h44;
  localparam logic [7:0] D_CLEAR   = 8'h01;
  localparam logic [7:0] D_RANGE05 = 8'h11;
  localparam logic [7:0] D_EXTREF  = 8'h02;
  localparam logic [7:0] D_TWOLANE = 8'h40;

  typedef struct packed {
    logic       bcast;
    logic [7:0] addr;
    logic [7:0] data;
  } wr_op_t;
endpackage

// File: rtl/dac_init_timer.sv
module dac_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dac_init_table.sv
module dac_init_table
  import dac_init_pkg::*;
#(
  parameter int NUM_CHIPS = 16,
  parameter int STEP_W    = 7,
  parameter int CHIP_W    = 4
) (
  input  logic [STEP_W-1:0] step_i,
  output wr_op_t            op_o,
  output logic [CHIP_W-1:0] chip_o,
  output logic              last_o
);
  localparam int CHIP_END = 3 + 4 * NUM_CHIPS;

  logic [STEP_W-1:0] rel;

  always_comb begin
    rel    = step_i - STEP_W'(3);
    chip_o = rel[CHIP_W+1:2];
    op_o   = '{bcast: 1'b1, addr: A_XFER, data: D_TWOLANE};
    last_o = 1'b0;
    if (step_i == STEP_W'(0)) begin
      op_o = '{bcast: 1'b1, addr: A_IFCFG, data: D_PULLUP};
    end else if (step_i == STEP_W'(1) || step_i == STEP_W'(CHIP_END)) begin
      op_o = '{bcast: 1'b1, addr: A_IFSTAT, data: D_CLEAR};
    end else if (step_i == STEP_W'(2) || step_i == STEP_W'(CHIP_END + 1)) begin
      op_o = '{bcast: 1'b1, addr: A_ERRSTAT, data: D_CLEAR};
    end else if (step_i < STEP_W'(CHIP_END)) begin
      unique case (rel[1:0])
        2'd0:    op_o = '{bcast: 1'b0, addr: A_LOAD16, data: 8'h00};
        2'd1:    op_o = '{bcast: 1'b0, addr: A_LOAD24, data: 8'h00};
        2'd2:    op_o = '{bcast: 1'b0, addr: A_RANGE,  data: D_RANGE05};
        default: op_o = '{bcast: 1'b0, addr: A_VREF,   data: D_EXTREF};
      endcase
    end else begin
      last_o = 1'b1;
    end
  end
endmodule

// File: rtl/dac_init_ctrl.sv
module dac_init_ctrl
  import dac_init_pkg::*;
#(
  parameter int               STEP_W      = 7,
  parameter int               CNT_W       = 8,
  parameter logic [CNT_W-1:0] HOLD_LAST   = '0,
  parameter logic [CNT_W-1:0] SETTLE_LAST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_done_i,
  input  logic              last_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output seq_state_e        state_o,
  output logic [STEP_W-1:0] step_o,
  output logic              tmr_clr_o,
  output logic              tmr_en_o
);
  logic hold_hit, settle_hit;

  assign hold_hit   = (state_o == ST_HOLD)   && (cnt_i == HOLD_LAST);
  assign settle_hit = (state_o == ST_SETTLE) && (cnt_i == SETTLE_LAST);
  assign tmr_en_o   = (state_o == ST_HOLD) || (state_o == ST_SETTLE);
  assign tmr_clr_o  = start_i || hold_hit || !tmr_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      step_o  <= '0;
    end else if (start_i) begin
      state_o <= ST_HOLD;
      step_o  <= '0;
    end else begin
      unique case (state_o)
        ST_HOLD:   if (hold_hit) state_o <= ST_SETTLE;
        ST_SETTLE: if (settle_hit) state_o <= ST_ISSUE;
        ST_ISSUE: begin
          if (wr_done_i) begin
            if (last_i) begin
              state_o <= ST_DONE;
            end else begin
              state_o <= ST_GAP;
              step_o  <= step_o + 1'b1;
            end
          end
        end
        ST_GAP:  state_o <= ST_ISSUE;
        default: state_o <= state_o;
      endcase
    end
  end
endmodule

// File: rtl/dac_init_seq.sv
module dac_init_seq
  import dac_init_pkg::*;
#(
  parameter int NUM_CHIPS   = 16,
  parameter int HOLD_CYCLES = 64,
  parameter int CLK_HZ      = 250_000_000,
  parameter int SETTLE_MS   = 300
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 alert_ni,
  input  logic                 wr_done_i,
  output logic                 dac_rst_no,
  output logic                 wr_req_o,
  output logic [BYTE_W-1:0]    wr_addr_o,
  output logic [BYTE_W-1:0]    wr_data_o,
  output logic [NUM_CHIPS-1:0] wr_cs_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 alert_o
);
  localparam longint SETTLE_L   = (longint'(CLK_HZ) * longint'(SETTLE_MS)) / 64'd1000;
  localparam int     SETTLE_CYC = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);
  localparam int     HOLD_CYC   = (HOLD_CYCLES < 1) ? 1 : HOLD_CYCLES;
  localparam int     CNT_MAX    = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int     CNT_W      = $clog2(CNT_MAX + 1);
  localparam int     NUM_STEPS  = 4 * NUM_CHIPS + 6;
  localparam int     STEP_W     = $clog2(NUM_STEPS);
  localparam int     CHIP_W     = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cnt;
  logic              tmr_clr, tmr_en, last;
  wr_op_t            op;
  logic [CHIP_W-1:0] chip;
  logic [1:0]        alert_sync;

  dac_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .en_i(tmr_en), .cnt_o(cnt)
  );

  dac_init_ctrl #(
    .STEP_W(STEP_W), .CNT_W(CNT_W), .HOLD_LAST(HOLD_LAST), .SETTLE_LAST(SETTLE_LAST)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .wr_done_i(wr_done_i),
    .last_i   (last),
    .cnt_i    (cnt),
    .state_o  (state),
    .step_o   (step),
    .tmr_clr_o(tmr_clr),
    .tmr_en_o (tmr_en)
  );

  dac_init_table #(.NUM_CHIPS(NUM_CHIPS), .STEP_W(STEP_W), .CHIP_W(CHIP_W)) u_table (
    .step_i(step), .op_o(op), .chip_o(chip), .last_o(last)
  );

  assign wr_req_o   = (state == ST_ISSUE);
  assign wr_addr_o  = op.addr;
  assign wr_data_o  = op.data;
  assign dac_rst_no = !((state == ST_IDLE) || (state == ST_HOLD));
  assign done_o     = (state == ST_DONE);
  assign busy_o     = !((state == ST_IDLE) || (state == ST_DONE));

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_cs
    assign wr_cs_o[g] = wr_req_o && (op.bcast || (chip == CHIP_W'(g)));
  end

  // two-flop synchronizer on the asynchronous alert pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_sync <= 2'b11;
    else         alert_sync <= {alert_sync[0], alert_ni};
  end
  assign alert_o = !alert_sync[1];
endmodule

// File: rtl/dac_init_seq_chk.sv
module dac_init_seq_chk #(
  parameter int NUM_CHIPS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 alert_ni,
  input logic                 wr_done_i,
  input logic                 dac_rst_no,
  input logic                 wr_req_o,
  input logic [7:0]           wr_addr_o,
  input logic [7:0]           wr_data_o,
  input logic [NUM_CHIPS-1:0] wr_cs_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 alert_o
);
  logic [1:0] age;
  logic       alert_d1, alert_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age      <= '0;
      alert_d1 <= 1'b1;
      alert_d2 <= 1'b1;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      alert_d1 <= alert_ni;
      alert_d2 <= alert_d1;
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_done_i && !start_i) |=>
      (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_cs_o)));

  assert_gap_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_done_i) |=> !wr_req_o);

  assert_quiet_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_rst_no |-> !wr_req_o);

  assert_cs_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> ($countones(wr_cs_o) == 1 || (&wr_cs_o)));

  assert_no_cs_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_o |-> (wr_cs_o == '0));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_done_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && dac_rst_no && !wr_req_o));

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!dac_rst_no && !wr_req_o && busy_o));

  assert_alert_delay_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (alert_o == !alert_d2));
endmodule

bind dac_init_seq dac_init_seq_chk #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .alert_ni  (alert_ni),
  .wr_done_i (wr_done_i),
  .dac_rst_no(dac_rst_no),
  .wr_req_o  (wr_req_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .wr_cs_o   (wr_cs_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .alert_o   (alert_o)
);

// File: tb/dac_init_seq_test.sv
`timescale 1ns/1ps
module dac_init_seq_test;
  localparam int N  = 16;
  localparam int H  = 8;
  localparam int HZ = 50_000;
  localparam int MS = 300;
  localparam int S  = HZ * MS / 1000;
  localparam int LIMIT = 150_000;

  localparam int P_IDLE = 0, P_HOLD = 1, P_SETTLE = 2, P_ISSUE = 3, P_GAP = 4, P_DONE = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, alert_n = 1'b1, done_in = 1'b0;
  logic dac_rst_n, req, busy, done, alert;
  logic [7:0] addr, data;
  logic [N-1:0] cs;

  dac_init_seq #(.NUM_CHIPS(N), .HOLD_CYCLES(H), .CLK_HZ(HZ), .SETTLE_MS(MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .alert_ni(alert_n), .wr_done_i(done_in),
    .dac_rst_no(dac_rst_n), .wr_req_o(req), .wr_addr_o(addr), .wr_data_o(data),
    .wr_cs_o(cs), .busy_o(busy), .done_o(done), .alert_o(alert)
  );

  always #2 clk = ~clk;

  int q_addr[$], q_data[$];
  logic [N-1:0] q_cs[$];
  string q_tag[$];

  int compared = 0, mismatched = 0, cyc = 0;
  int m_ph = P_IDLE, m_cnt = 0, m_idx = 0;
  logic a1 = 1'b1, a2 = 1'b1;

  task automatic push(int a, int d, logic [N-1:0] c, string t);
    q_addr.push_back(a); q_data.push_back(d); q_cs.push_back(c); q_tag.push_back(t);
  endtask

  task automatic build();
    push('h14, 'h44, '1, "R3");
    push('h11, 'h01, '1, "R4");
    push('h17, 'h01, '1, "R4");
    for (int c = 0; c < N; c++) begin
      logic [N-1:0] one;
      one = '0; one[c] = 1'b1;
      push('h1C, 'h00, one, "R5");
      push('h1D, 'h00, one, "R5");
      push('h1A, 'h11, one, "R5");
      push('h15, 'h02, one, "R5");
    end
    push('h11, 'h01, '1, "R4");
    push('h17, 'h01, '1, "R4");
    push('h0F, 'h40, '1, "R6");
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= P_IDLE; m_cnt <= 0; m_idx <= 0; a1 <= 1'b1; a2 <= 1'b1;
    end else begin
      a1 <= alert_n; a2 <= a1;
      if (start) begin
        m_ph <= P_HOLD; m_cnt <= 0; m_idx <= 0;
      end else if (m_ph == P_HOLD) begin
        if (m_cnt == H - 1) begin m_ph <= P_SETTLE; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else if (m_ph == P_SETTLE) begin
        if (m_cnt == S - 1) begin m_ph <= P_ISSUE; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else if (m_ph == P_ISSUE) begin
        if (done_in) begin
          if (m_idx == q_addr.size() - 1) m_ph <= P_DONE;
          else begin m_ph <= P_GAP; m_idx <= m_idx + 1; end
        end
      end else if (m_ph == P_GAP) begin
        m_ph <= P_ISSUE;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    logic e_req;
    e_req = (m_ph == P_ISSUE);
    chk("R1 R10 dac_rst_no", int'(dac_rst_n), int'(!(m_ph == P_IDLE || m_ph == P_HOLD)));
    chk("R2 R7 wr_req_o", int'(req), int'(e_req));
    chk("R9 done_o", int'(done), int'(m_ph == P_DONE));
    chk("R9 busy_o", int'(busy), int'(!(m_ph == P_IDLE || m_ph == P_DONE)));
    chk("R11 alert_o", int'(alert), int'(!a2));
    if (e_req) begin
      chk({q_tag[m_idx], " addr"}, int'(addr), q_addr[m_idx]);
      chk({q_tag[m_idx], " data"}, int'(data), q_data[m_idx]);
      chk({q_tag[m_idx], " cs"}, int'(cs), int'(q_cs[m_idx]));
    end else begin
      chk("R5 cs idle", int'(cs), 0);
    end
  endtask

  logic start_req = 1'b0, spur_req = 1'b0, eng = 1'b0;
  int wt = 0, lat = 0;

  task automatic tick();
    @(negedge clk);
    check_all();
    cyc++;
    start = start_req; start_req = 1'b0;
    done_in = 1'b0;
    if (spur_req) begin
      if (!req) done_in = 1'b1;
      spur_req = 1'b0;
    end else if (req) begin
      if (!eng) begin eng = 1'b1; wt = lat; lat = (lat + 1) % 4; end
      if (wt == 0) begin done_in = 1'b1; eng = 1'b0; end
      else wt--;
    end
    alert_n = !((cyc % 41) < 6);
  endtask

  task automatic run_until(int ph, int idx);
    while (!(m_ph == ph && (idx < 0 || m_idx == idx)) && cyc < LIMIT) tick();
    if (cyc >= LIMIT) begin
      mismatched++;
      $display("FAIL R9 watchdog: actual phase %0d expected %0d", m_ph, ph);
    end
  endtask

  initial begin
    build();
    repeat (3) tick();
    chk("R1 reset dac_rst_no", int'(dac_rst_n), 0);
    chk("R11 reset alert_o", int'(alert), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R9 idle done_o", int'(done), 0);

    // first run, with a stray done pulse during settling (R8)
    start_req = 1'b1;
    run_until(P_SETTLE, -1);
    repeat (50) tick();
    spur_req = 1'b1;
    tick(); tick();
    chk("R8 no request after stray done", int'(req), 0);
    run_until(P_DONE, -1);
    repeat (5) tick();
    spur_req = 1'b1;
    tick(); tick();
    chk("R8 done_o kept after stray done", int'(done), 1);
    chk("R8 no request in done", int'(req), 0);

    // second run, restarted in the middle of the per-chip writes (R10)
    start_req = 1'b1;
    tick();
    run_until(P_ISSUE, 13);
    start_req = 1'b1;
    tick(); tick();
    chk("R10 reset line low after restart", int'(dac_rst_n), 0);
    chk("R10 no request after restart", int'(req), 0);
    run_until(P_DONE, -1);
    chk("R6 final completion", int'(done), 1);
    repeat (3) tick();

    if (cyc >= LIMIT) mismatched++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 190_000);
    mismatched++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule